// File: doc/BRIEF.md
# Deep Pipeline Interlock Unit

This block decides, every cycle, whether the instruction waiting in the decode/operand-fetch stage of an in-order eight-stage integer pipeline may move on. The stages are fetch, decode, execute, four memory stages (M0 to M3) and writeback. The block compares the two source indices of the decode instruction with the destination index, valid bit and category of each producer in execute and M0 to M3. A match blocks decode only when that producer's category has not yet produced its result at the stage where the producer sits. Loads and floating-point results are the last to become available. Stores block only while they are in execute. Simple ALU results never block.

The block also handles two other cases. A memory-stage structural conflict arises when the instruction in M0 is a load or store and an older load or store that may trap is still in M1, M2 or M3. In that case everything up to and including M0 is frozen and a bubble goes into M1. The second case is a busy multi-cycle unit, which holds fetch and decode. A data stall or a busy unit freezes fetch and decode and puts a bubble into execute. A registered cause code reports, one cycle later, why the pipe was held.

Top module: `pipe_interlock`

## Requirements
- R1: With no valid decode instruction, no busy multi-cycle unit and no structural conflict, stall_of, bubble_ex and stall_m0 are all 0.
- R2: A valid execute-stage producer whose destination equals an enabled, nonzero decode source stalls decode (stall_of=1, bubble_ex=1) for every category except ALU (category code 0). The category codes are: 0 ALU, 1 load, 2 store, 3 multiply, 4 divide, 5 remainder, 6 floating-point, 7 multi-cycle floating-point.
- R3: A matching producer in M0 stalls decode only for categories 1, 3, 4, 5, 6 and 7.
- R4: A matching producer in M1 or M2 stalls decode only for categories 1, 4, 5, 6 and 7.
- R5: A matching producer in M3 stalls decode only for categories 1, 6 and 7.
- R6: Destination index 0, a disabled source, an invalid producer or an invalid decode instruction never causes a data stall.
- R7: When M0 holds a valid load or store, and M1, M2 or M3 holds a valid load or store whose may-trap flag is set, stall_m0=1 and stall_of=1 and bubble_ex=0. mem_trap bit 0 belongs to M1, bit 1 to M2 and bit 2 to M3.
- R8: While mc_busy=1 and no structural conflict is present, stall_of=1 and bubble_ex=1.
- R9: A load producer that advances one stage per cycle, from execute to writeback, holds a dependent decode instruction for exactly 5 cycles. A divide producer holds it for 4 cycles and a multiply producer for 2.
- R10: cause_q reads 0 after reset. One clock edge after any set of inputs it shows the cause, chosen in this priority order: 1 structural, 2 busy multi-cycle unit, then 3+k for the matching producer nearest to decode (k=0 execute, 1 M0, 2 M1, 3 M2, 4 M3). With no cause it shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| of_valid | input | 1 | Decode stage holds a valid instruction |
| of_rs1 | input | 5 | First source index |
| of_rs1_en | input | 1 | First source is read |
| of_rs2 | input | 5 | Second source index |
| of_rs2_en | input | 1 | Second source is read |
| pr_valid | input | 5 | Producer valid, bit 0 execute, bits 1..4 M0..M3 |
| pr_rd | input | 5x5 | Producer destination index per stage |
| pr_cat | input | 5x3 | Producer category code per stage |
| mem_trap | input | 3 | May-trap flag for M1, M2, M3 |
| mc_busy | input | 1 | Multi-cycle unit busy |
| stall_of | output | 1 | Freeze fetch and decode |
| bubble_ex | output | 1 | Insert an invalid slot into execute |
| stall_m0 | output | 1 | Freeze up to and including M0, bubble into M1 |
| cause_q | output | 3 | Registered stall cause code |

## Verification
stall_of, bubble_ex and stall_m0 are combinational, so their value is due in the same cycle as the stimulus. The bench applies new inputs on the falling clock edge and checks these three outputs one nanosecond later, well before the next rising edge. cause_q passes through one register, so it is due after the next rising edge. The bench saves the expected code for each stimulus and compares it at the following falling edge, just before it applies the next set of inputs. The R9 sequences shift a producer one stage per cycle and count the cycles in which stall_of is high.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    CAT_ALU  = 3'd0,
    CAT_LOAD = 3'd1,
    CAT_STOR = 3'd2,
    CAT_MUL  = 3'd3,
    CAT_DIV  = 3'd4,
    CAT_REM  = 3'd5,
    CAT_FP   = 3'd6,
    CAT_FPMC = 3'd7
  } cat_e;

  // Number of producer stages (execute = 0) through which a category's
  // result is still unavailable to decode.
  function automatic int unsigned blk_depth(input cat_e c);
    case (c)
      CAT_ALU:          blk_depth = 0;
      CAT_STOR:         blk_depth = 1;
      CAT_MUL:          blk_depth = 2;
      CAT_DIV, CAT_REM: blk_depth = 4;
      default:          blk_depth = 5;
    endcase
  endfunction

  function automatic logic is_mem(input cat_e c);
    is_mem = (c == CAT_LOAD) || (c == CAT_STOR);
  endfunction

endpackage

// File: rtl/ilk_match.sv
module ilk_match
  import ilk_pkg::*;
#(
  parameter int RW  = 5,
  parameter int STG = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_valid,
  input  logic [RW-1:0] rs1,
  input  logic          rs1_en,
  input  logic [RW-1:0] rs2,
  input  logic          rs2_en,
  input  logic          pv,
  input  logic [RW-1:0] prd,
  input  logic [2:0]    pcat,
  output logic          hit
);

  logic dep;
  logic late;

  always_comb begin
    dep  = pv && (prd != '0) &&
           ((rs1_en && (rs1 == prd)) || (rs2_en && (rs2 == prd)));
    late = (STG < blk_depth(cat_e'(pcat)));
    hit  = src_valid && dep && late;
  end

  // R6: register zero never blocks decode
  a_r6_zero_free: assert property (@(posedge clk) disable iff (!rst_n)
    (prd == '0) |-> !hit);

  // R6: an invalid producer never blocks decode
  a_r6_invalid_free: assert property (@(posedge clk) disable iff (!rst_n)
    !pv |-> !hit);

endmodule

// File: rtl/ilk_struct.sv
module ilk_struct
  import ilk_pkg::*;
#(
  parameter int NMEM = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NMEM-1:0]          m_valid,
  input  logic [NMEM-1:0][2:0]     m_cat,
  input  logic [NMEM-2:0]          m_trap,
  output logic                     conflict
);

  logic [NMEM-2:0] older_risky;

  genvar j;
  generate
    for (j = 1; j < NMEM; j++) begin : g_old
      assign older_risky[j-1] = m_valid[j] && is_mem(cat_e'(m_cat[j])) && m_trap[j-1];
    end
  endgenerate

  assign conflict = m_valid[0] && is_mem(cat_e'(m_cat[0])) && (|older_risky);

  // R7: a conflict needs a memory access in M0
  a_r7_m0_mem: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (m_valid[0] && (m_cat[0] == 3'd1 || m_cat[0] == 3'd2)));

  // R7: without any trap flag there is no conflict
  a_r7_needs_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (m_trap == '0) |-> !conflict);

endmodule

// File: rtl/ilk_cause.sv
module ilk_cause #(
  parameter int NPROD = 5,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conflict,
  input  logic             mc_busy,
  input  logic [NPROD-1:0] hits,
  output logic [CW-1:0]    cause_q
);

  localparam logic [CW-1:0] C_NONE = '0;
  localparam logic [CW-1:0] C_STR  = CW'(1);
  localparam logic [CW-1:0] C_MC   = CW'(2);

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic [CW-1:0] cause_d;
  logic          cause_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    cause_d = C_NONE;
    for (int i = NPROD - 1; i >= 0; i--) begin
      if (hits[i]) cause_d = CW'(3 + i);
    end
    if (mc_busy)  cause_d = C_MC;
    if (conflict) cause_d = C_STR;
    cause_en = (cause_d != cause_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   cause_q <= C_NONE;
    else if (cause_en) cause_q <= cause_d;
  end

  // R10: with nothing holding the pipe the code returns to zero
  a_r10_idle_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!conflict && !mc_busy && hits == '0) |=> (cause_q == C_NONE));

  // R10: a structural conflict outranks everything
  a_r10_struct_first: assert property (@(posedge clk) disable iff (!rst_sync_n)
    conflict |=> (cause_q == C_STR));

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import ilk_pkg::*;
#(
  parameter int RW   = 5,
  parameter int NMEM = 4,
  localparam int NPROD = NMEM + 1,
  localparam int CW    = $clog2(NPROD + 3)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    of_valid,
  input  logic [RW-1:0]           of_rs1,
  input  logic                    of_rs1_en,
  input  logic [RW-1:0]           of_rs2,
  input  logic                    of_rs2_en,
  input  logic [NPROD-1:0]        pr_valid,
  input  logic [NPROD-1:0][RW-1:0] pr_rd,
  input  logic [NPROD-1:0][2:0]   pr_cat,
  input  logic [NMEM-2:0]         mem_trap,
  input  logic                    mc_busy,
  output logic                    stall_of,
  output logic                    bubble_ex,
  output logic                    stall_m0,
  output logic [CW-1:0]           cause_q
);

  logic [NPROD-1:0] hits;
  logic             conflict;
  logic             data_hz;

  genvar k;
  generate
    for (k = 0; k < NPROD; k++) begin : g_prod
      ilk_match #(.RW(RW), .STG(k)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_valid(of_valid),
        .rs1      (of_rs1),
        .rs1_en   (of_rs1_en),
        .rs2      (of_rs2),
        .rs2_en   (of_rs2_en),
        .pv       (pr_valid[k]),
        .prd      (pr_rd[k]),
        .pcat     (pr_cat[k]),
        .hit      (hits[k])
      );
    end
  endgenerate

  ilk_struct #(.NMEM(NMEM)) u_struct (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_valid (pr_valid[NPROD-1:1]),
    .m_cat   (pr_cat[NPROD-1:1]),
    .m_trap  (mem_trap),
    .conflict(conflict)
  );

  ilk_cause #(.NPROD(NPROD), .CW(CW)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .conflict(conflict),
    .mc_busy (mc_busy),
    .hits    (hits),
    .cause_q (cause_q)
  );

  always_comb begin
    data_hz   = |hits;
    stall_m0  = conflict;
    stall_of  = conflict || mc_busy || data_hz;
    bubble_ex = (mc_busy || data_hz) && !conflict;
  end

  // R7: a structural hold freezes execute rather than emptying it
  a_r7_front_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall_m0 |-> (stall_of && !bubble_ex));

  // R8: a busy multi-cycle unit always holds decode
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mc_busy |-> stall_of);

  // R1: an idle decode slot with no other cause never stalls
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!of_valid && !mc_busy && !stall_m0) |-> (!stall_of && !bubble_ex));

endmodule

// File: tb/tb_pipe_interlock.sv
module tb_pipe_interlock;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           of_valid;
  logic [4:0]     of_rs1, of_rs2;
  logic           of_rs1_en, of_rs2_en;
  logic [4:0]     pr_valid;
  logic [4:0][4:0] pr_rd;
  logic [4:0][2:0] pr_cat;
  logic [2:0]     mem_trap;
  logic           mc_busy;
  logic           stall_of, bubble_ex, stall_m0;
  logic [2:0]     cause_q;

  int n_chk = 0;
  int n_err = 0;
  logic [2:0] exp_cause_prev = 3'd0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pipe_interlock dut (
    .clk(clk), .rst_n(rst_n), .of_valid(of_valid),
    .of_rs1(of_rs1), .of_rs1_en(of_rs1_en), .of_rs2(of_rs2), .of_rs2_en(of_rs2_en),
    .pr_valid(pr_valid), .pr_rd(pr_rd), .pr_cat(pr_cat), .mem_trap(mem_trap),
    .mc_busy(mc_busy), .stall_of(stall_of), .bubble_ex(bubble_ex),
    .stall_m0(stall_m0), .cause_q(cause_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // does a category at stage s (0 execute .. 4 M3) still withhold its result
  function automatic bit late_at(input int s, input logic [2:0] c);
    case (s)
      0: return c != 3'd0;
      1: return c inside {3'd1, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
      2, 3: return c inside {3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
      default: return c inside {3'd1, 3'd6, 3'd7};
    endcase
  endfunction

  function automatic bit ldst(input logic [2:0] c);
    return (c == 3'd1) || (c == 3'd2);
  endfunction

  task automatic ref_model(output bit e_stall, output bit e_bub, output bit e_m0,
                           output logic [2:0] e_cause);
    bit data = 0;
    bit str  = 0;
    e_cause = 3'd0;
    for (int s = 4; s >= 0; s--) begin
      if (of_valid && pr_valid[s] && pr_rd[s] != 5'd0 && late_at(s, pr_cat[s]) &&
          ((of_rs1_en && of_rs1 == pr_rd[s]) || (of_rs2_en && of_rs2 == pr_rd[s]))) begin
        data = 1;
        e_cause = 3'(3 + s);
      end
    end
    if (pr_valid[1] && ldst(pr_cat[1]))
      for (int m = 0; m < 3; m++)
        if (pr_valid[m+2] && ldst(pr_cat[m+2]) && mem_trap[m]) str = 1;
    if (mc_busy) e_cause = 3'd2;
    if (str)     e_cause = 3'd1;
    e_m0    = str;
    e_stall = str || mc_busy || data;
    e_bub   = (mc_busy || data) && !str;
  endtask

  // inputs must be set before calling; call right after a falling edge
  task automatic step(input string req);
    bit es, eb, em;
    logic [2:0] ec;
    #1;
    ref_model(es, eb, em, ec);
    chk(req, "stall_of", int'(stall_of), int'(es));
    chk(req, "bubble_ex", int'(bubble_ex), int'(eb));
    chk(req, "stall_m0", int'(stall_m0), int'(em));
    exp_cause_prev = ec;
    @(negedge clk);
    chk("R10", "cause_q", int'(cause_q), int'(exp_cause_prev));
  endtask

  task automatic clear_in();
    of_valid = 0; of_rs1 = 0; of_rs2 = 0; of_rs1_en = 0; of_rs2_en = 0;
    pr_valid = '0; pr_rd = '0; pr_cat = '0; mem_trap = '0; mc_busy = 0;
  endtask

  task automatic consumer(input logic [4:0] r);
    of_valid = 1; of_rs1 = r; of_rs1_en = 1; of_rs2 = 5'd9; of_rs2_en = 1;
  endtask

  // producer of category c walks from execute to writeback; count stall cycles
  task automatic walk(input logic [2:0] c, input int want, input string req);
    int cnt = 0;
    for (int s = 0; s < 6; s++) begin
      clear_in();
      consumer(5'd5);
      if (s < 5) begin
        pr_valid[s] = 1; pr_rd[s] = 5'd5; pr_cat[s] = c;
      end
      #1;
      if (stall_of) cnt++;
      step(req);
    end
    chk(req, "stall cycles", cnt, want);
  endtask

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 / R1: reset state
    chk("R10", "cause_q after reset", int'(cause_q), 0);
    step("R1");

    // R2: every category against an execute-stage producer
    for (int c = 0; c < 8; c++) begin
      clear_in(); consumer(5'd7);
      pr_valid[0] = 1; pr_rd[0] = 5'd7; pr_cat[0] = 3'(c);
      step("R2");
    end
    // R3, R4, R5: each memory stage, each category, through the second source
    for (int s = 1; s < 5; s++)
      for (int c = 0; c < 8; c++) begin
        clear_in(); of_valid = 1; of_rs2 = 5'd12; of_rs2_en = 1;
        pr_valid[s] = 1; pr_rd[s] = 5'd12; pr_cat[s] = 3'(c);
        step(s == 1 ? "R3" : (s == 4 ? "R5" : "R4"));
      end
    // R6: register zero, disabled source, invalid producer, invalid decode
    clear_in(); of_valid = 1; of_rs1_en = 1; pr_valid[0] = 1; pr_cat[0] = 3'd1;
    step("R6");
    clear_in(); of_valid = 1; of_rs1 = 5'd3; pr_valid[1] = 1; pr_rd[1] = 5'd3; pr_cat[1] = 3'd1;
    step("R6");
    clear_in(); consumer(5'd4); pr_rd[0] = 5'd4; pr_cat[0] = 3'd6;
    step("R6");
    clear_in(); consumer(5'd4); of_valid = 0; pr_valid[0] = 1; pr_rd[0] = 5'd4; pr_cat[0] = 3'd6;
    step("R6");
    // R7: structural conflict for each older stage, then without trap flag
    for (int m = 0; m < 3; m++) begin
      clear_in(); consumer(5'd8); pr_valid[0] = 1; pr_rd[0] = 5'd8; pr_cat[0] = 3'd1;
      pr_valid[1] = 1; pr_cat[1] = 3'd2;
      pr_valid[m+2] = 1; pr_cat[m+2] = 3'd1; mem_trap[m] = 1;
      step("R7");
    end
    clear_in(); pr_valid[1] = 1; pr_cat[1] = 3'd1; pr_valid[2] = 1; pr_cat[2] = 3'd1;
    step("R7");
    // R8: busy multi-cycle unit, with and without a data hazard
    clear_in(); mc_busy = 1;
    step("R8");
    clear_in(); mc_busy = 1; consumer(5'd2); pr_valid[3] = 1; pr_rd[3] = 5'd2; pr_cat[3] = 3'd4;
    step("R8");
    // R9: stall lengths as producers advance
    walk(3'd1, 5, "R9");
    walk(3'd4, 4, "R9");
    walk(3'd3, 2, "R9");
    walk(3'd0, 0, "R9");
    // random mix, checked against the bench model (R2..R8, R10)
    void'($urandom(32'd4242));
    for (int it = 0; it < 3000; it++) begin
      of_valid  = 1'($urandom_range(0, 9) != 0);
      of_rs1    = 5'($urandom_range(0, 3));
      of_rs2    = 5'($urandom_range(0, 3));
      of_rs1_en = 1'($urandom_range(0, 1));
      of_rs2_en = 1'($urandom_range(0, 1));
      for (int s = 0; s < 5; s++) begin
        pr_valid[s] = 1'($urandom_range(0, 2) != 0);
        pr_rd[s]    = 5'($urandom_range(0, 3));
        pr_cat[s]   = 3'($urandom_range(0, 7));
      end
      mem_trap = 3'($urandom_range(0, 7) & $urandom_range(0, 7));
      mc_busy  = 1'($urandom_range(0, 7) == 0);
      step("R2-R8 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule